// File: doc/BRIEF.md
# Parallel 8080-Style Panel Frame Writer

This block sends one frame of pixels into the frame memory of a smart display panel over an 8080-style parallel bus. The bus has three parts: an active-low chip select, an active-low write strobe and a data word. Each pixel is taken from a valid/ready stream and presented as one bus write. Four programmable cycle counts set the shape of every write: the select-to-setup interval, the write setup, the strobe-low time and the data hold.

A frame starts in one of two ways. Software can issue a command through the trigger control word, or a rising edge on the panel's tearing-effect line can start it once hardware triggering is enabled. Hardware triggering can be masked. It can fire on every tearing pulse, or only once per write of the control word. A request that arrives while a frame is in flight is dropped and not queued, because extra triggers can upset the panel. The bus clock is meant to run at about twice the pixel rate, so that a frame ends before the next tearing pulse. At the end of a frame a pending interrupt is set. It stays set until software clears it.

Top module: `i80_panel_writer`

## Requirements
- R1: The timing word is decoded as follows: bit 0 is the interface enable; bits 19:16 give the chip-select setup; bits 15:12 the write setup; bits 11:8 the write-active time; bits 7:4 the write hold. For every pixel, chip select is low for exactly setup+write-setup cycles before the write strobe falls.
- R2: The write strobe stays low for the write-active count of cycles. A write-active field of 0 gives one cycle.
- R3: After the strobe rises, chip select stays low for exactly the hold count of cycles. The data word is stable for as long as chip select is low. Chip select goes high between any two pixels.
- R4: One frame writes exactly FRAME_PIXELS pixels, in the order the stream delivers them. A pixel is taken only on a cycle where valid and ready are both high.
- R5: A write of the trigger word with bit 0 (trigger mode) and bit 1 (software command) both set starts a frame. A write that has only one of the two bits set starts nothing. Bit 1 is not stored.
- R6: Bit 3 enables starting on a tearing-effect rising edge, and bit 4 masks those edges. With bit 31 set, every unmasked edge starts a frame. With bit 31 clear, only the first edge after a trigger-word write that sets bit 3 starts a frame.
- R7: Software or tearing-effect requests that arrive while a frame is in progress are dropped, with no frame started afterwards.
- R8: While the interface enable bit is 0, every trigger request is discarded.
- R9: The busy output rises in the cycle after a trigger is accepted. It falls when the hold phase of the last pixel ends.
- R10: The interrupt output goes high in the same cycle busy falls. It stays high until an irq_clr pulse.
- R11: The timing word is captured when a frame starts. Changes to it during the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timing | input | 32 | Timing and enable word |
| trig_we | input | 1 | One-cycle write strobe for the trigger word |
| trig_wdata | input | 32 | Trigger word value |
| te_in | input | 1 | Tearing-effect line from the panel (asynchronous) |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready |
| irq_clr | input | 1 | Write-one clear of the frame-done interrupt |
| lcd_cs_n | output | 1 | Bus chip select, active low |
| lcd_wr_n | output | 1 | Bus write strobe, active low |
| lcd_data | output | DATA_W | Bus data |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Frame-done interrupt pending |

## Verification
The hardest case to reach is a second trigger arriving while a frame is in flight, and the variant where a one-shot tearing arm has already been used. From the ports the only evidence is a missing extra frame. The stimulus uses long phase counts so that frames last about a hundred cycles. It then issues software commands, re-arming writes and tearing pulses in the middle of the frame. Afterwards it checks that exactly one frame's worth of pixels appeared and that busy stays low.

// File: rtl/i80_pkg.sv
package i80_pkg;

  localparam int FIELD_W       = 4;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_HOLD_LSB  = 4;
  localparam int CFG_ACT_LSB   = 8;
  localparam int CFG_WRS_LSB   = 12;
  localparam int CFG_CSS_LSB   = 16;

  localparam int TRG_MODE_BIT  = 0;
  localparam int TRG_SW_BIT    = 1;
  localparam int TRG_HW_BIT    = 3;
  localparam int TRG_MASK_BIT  = 4;
  localparam int TRG_PERTE_BIT = 31;

  typedef struct packed {
    logic [FIELD_W-1:0] css;
    logic [FIELD_W-1:0] wrs;
    logic [FIELD_W-1:0] act;
    logic [FIELD_W-1:0] hold;
  } i80_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_CSS   = 3'd2,
    PH_WRS   = 3'd3,
    PH_ACT   = 3'd4,
    PH_HOLD  = 3'd5
  } phase_e;

  function automatic i80_timing_t decode_timing(input logic [31:0] cfg);
    i80_timing_t t;
    t.css  = cfg[CFG_CSS_LSB  +: FIELD_W];
    t.wrs  = cfg[CFG_WRS_LSB  +: FIELD_W];
    t.act  = cfg[CFG_ACT_LSB  +: FIELD_W];
    t.hold = cfg[CFG_HOLD_LSB +: FIELD_W];
    return t;
  endfunction

  // strobe-low time never drops below one cycle
  function automatic logic [FIELD_W-1:0] active_len(input i80_timing_t t);
    return (t.act == '0) ? FIELD_W'(1) : t.act;
  endfunction

  // first phase after a pixel is taken, skipping empty ones
  function automatic phase_e lead_phase(input i80_timing_t t);
    if (t.css != '0)      return PH_CSS;
    else if (t.wrs != '0) return PH_WRS;
    else                  return PH_ACT;
  endfunction

  // counter preload (length - 1) for a phase that is being entered
  function automatic logic [FIELD_W-1:0] phase_count(input phase_e p, input i80_timing_t t);
    case (p)
      PH_CSS:  return t.css - 1'b1;
      PH_WRS:  return t.wrs - 1'b1;
      PH_ACT:  return active_len(t) - 1'b1;
      PH_HOLD: return t.hold - 1'b1;
      default: return '0;
    endcase
  endfunction

  function automatic logic phase_selects(input phase_e p);
    return (p == PH_CSS) || (p == PH_WRS) || (p == PH_ACT) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/i80_trigger_ctrl.sv
module i80_trigger_ctrl
  import i80_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_we,
  input  logic [31:0] trig_wdata,
  input  logic        te_in,
  input  logic        if_en,
  input  logic        busy,
  output logic        start
);

  logic hw_en_q, hw_mask_q, per_te_q, armed_q;
  logic [SYNC_STAGES-1:0] te_sync;
  logic te_d;
  logic te_rise;
  logic sw_req, hw_req;
  logic wdata_unused;

  assign wdata_unused = ^{trig_wdata[30:5], trig_wdata[2]};

  // tearing-effect synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) te_sync <= '0;
        else        te_sync <= te_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) te_sync <= '0;
        else        te_sync <= {te_sync[SYNC_STAGES-2:0], te_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) te_d <= 1'b0;
    else        te_d <= te_sync[SYNC_STAGES-1];

  assign te_rise = te_sync[SYNC_STAGES-1] & ~te_d;

  assign sw_req = trig_we & trig_wdata[TRG_SW_BIT] & trig_wdata[TRG_MODE_BIT];
  assign hw_req = te_rise & hw_en_q & ~hw_mask_q & (per_te_q | armed_q);
  assign start  = if_en & ~busy & (sw_req | hw_req);

  // stored trigger word bits; the command bit is never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_en_q   <= 1'b0;
      hw_mask_q <= 1'b0;
      per_te_q  <= 1'b0;
      armed_q   <= 1'b0;
    end else if (trig_we) begin
      hw_en_q   <= trig_wdata[TRG_HW_BIT];
      hw_mask_q <= trig_wdata[TRG_MASK_BIT];
      per_te_q  <= trig_wdata[TRG_PERTE_BIT];
      armed_q   <= trig_wdata[TRG_HW_BIT];
    end else if (start && hw_req && !per_te_q) begin
      armed_q   <= 1'b0;
    end
  end

  assert_one_shot_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hw_req && !per_te_q && !trig_we) |=> !armed_q);

endmodule

// File: rtl/i80_strobe_seq.sv
module i80_strobe_seq
  import i80_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int FRAME_PIXELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  i80_timing_t       timing_i,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              frame_done
);

  localparam int PCW = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;
  localparam logic [PCW-1:0] LAST_PIX = PCW'(FRAME_PIXELS - 1);

  phase_e state, nxt_state;
  logic [FIELD_W-1:0] cnt, nxt_cnt;
  logic [PCW-1:0] pix_cnt, nxt_pix;
  i80_timing_t tq;
  logic pixel_end;

  always_comb begin
    nxt_state  = state;
    nxt_cnt    = cnt;
    nxt_pix    = pix_cnt;
    pix_ready  = 1'b0;
    pixel_end  = 1'b0;
    frame_done = 1'b0;
    case (state)
      PH_IDLE: begin
        if (start) begin
          nxt_state = PH_FETCH;
          nxt_pix   = '0;
        end
      end
      PH_FETCH: begin
        pix_ready = 1'b1;
        if (pix_valid) begin
          nxt_state = lead_phase(tq);
          nxt_cnt   = phase_count(nxt_state, tq);
        end
      end
      PH_CSS: begin
        if (cnt == '0) begin
          nxt_state = (tq.wrs != '0) ? PH_WRS : PH_ACT;
          nxt_cnt   = phase_count(nxt_state, tq);
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_WRS: begin
        if (cnt == '0) begin
          nxt_state = PH_ACT;
          nxt_cnt   = phase_count(PH_ACT, tq);
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_ACT: begin
        if (cnt == '0) begin
          if (tq.hold != '0) begin
            nxt_state = PH_HOLD;
            nxt_cnt   = phase_count(PH_HOLD, tq);
          end else pixel_end = 1'b1;
        end else nxt_cnt = cnt - 1'b1;
      end
      PH_HOLD: begin
        if (cnt == '0) pixel_end = 1'b1;
        else           nxt_cnt = cnt - 1'b1;
      end
      default: nxt_state = PH_IDLE;
    endcase
    if (pixel_end) begin
      if (pix_cnt == LAST_PIX) begin
        nxt_state  = PH_IDLE;
        frame_done = 1'b1;
      end else begin
        nxt_state = PH_FETCH;
        nxt_pix   = pix_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      pix_cnt  <= '0;
      tq       <= '0;
      bus_data <= '0;
      cs_n     <= 1'b1;
      wr_n     <= 1'b1;
    end else begin
      state   <= nxt_state;
      cnt     <= nxt_cnt;
      pix_cnt <= nxt_pix;
      cs_n    <= ~phase_selects(nxt_state);
      wr_n    <= (nxt_state != PH_ACT);
      if (state == PH_IDLE && start) tq <= timing_i;
      if (state == PH_FETCH && pix_valid) bus_data <= pix_data;
    end
  end

  assign busy = (state != PH_IDLE);

  assert_strobe_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(bus_data));

  assert_fetch_deselects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FETCH) |-> cs_n);

  assert_take_only_when_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(pix_ready && pix_valid));

endmodule

// File: rtl/i80_irq_ctrl.sv
module i80_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic irq_clr,
  output logic irq
);

  // a completion in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (irq_clr)    irq <= 1'b0;

  assert_pending_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/i80_panel_writer.sv
module i80_panel_writer
  import i80_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int FRAME_PIXELS = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_timing,
  input  logic              trig_we,
  input  logic [31:0]       trig_wdata,
  input  logic              te_in,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  input  logic              irq_clr,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy,
  output logic              irq
);

  logic start;
  logic frame_done;
  logic if_en;
  i80_timing_t timing;
  logic cfg_unused;

  assign if_en      = cfg_timing[CFG_EN_BIT];
  assign timing     = decode_timing(cfg_timing);
  assign cfg_unused = ^{cfg_timing[31:20], cfg_timing[3:1]};

  i80_trigger_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_we    (trig_we),
    .trig_wdata (trig_wdata),
    .te_in      (te_in),
    .if_en      (if_en),
    .busy       (busy),
    .start      (start)
  );

  i80_strobe_seq #(.DATA_W(DATA_W), .FRAME_PIXELS(FRAME_PIXELS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .timing_i   (timing),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .pix_ready  (pix_ready),
    .cs_n       (lcd_cs_n),
    .wr_n       (lcd_wr_n),
    .bus_data   (lcd_data),
    .busy       (busy),
    .frame_done (frame_done)
  );

  i80_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .irq_clr    (irq_clr),
    .irq        (irq)
  );

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_disabled_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !if_en) |=> !busy);

endmodule

// File: tb/tb_i80_panel_writer.sv
module tb_i80_panel_writer;

  localparam int DW = 16;
  localparam int NPIX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_timing = '0;
  logic trig_we = 1'b0;
  logic [31:0] trig_wdata = '0;
  logic te_in = 1'b0;
  logic pix_valid = 1'b1;
  logic [DW-1:0] src_val = '0;
  logic pix_ready;
  logic irq_clr = 1'b0;
  logic lcd_cs_n, lcd_wr_n, busy, irq;
  logic [DW-1:0] lcd_data;

  int n_chk = 0;
  int n_bad = 0;
  int exp_pre = 0, exp_act = 1, exp_post = 0;
  int writes = 0;
  int exp_data = 0;
  bit in_pix = 0, seen_wr = 0;
  int pre_c = 0, act_c = 0, post_c = 0;
  int last_data = 0;

  always #10 clk = ~clk;

  i80_panel_writer #(.DATA_W(DW), .FRAME_PIXELS(NPIX)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing), .trig_we(trig_we),
    .trig_wdata(trig_wdata), .te_in(te_in), .pix_valid(pix_valid),
    .pix_data(src_val), .pix_ready(pix_ready), .irq_clr(irq_clr),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data),
    .busy(busy), .irq(irq)
  );

  always @(posedge clk) if (pix_valid && pix_ready) src_val <= src_val + 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_cs_n) begin
        in_pix = 1;
        if (!lcd_wr_n) begin
          seen_wr = 1; act_c++; last_data = int'(lcd_data);
        end else if (seen_wr) post_c++;
        else pre_c++;
      end else if (in_pix) begin
        chk(pre_c == exp_pre,   "R1 setup cycles", pre_c, exp_pre);
        chk(act_c == exp_act,   "R2 strobe-low cycles", act_c, exp_act);
        chk(post_c == exp_post, "R3 hold cycles", post_c, exp_post);
        chk(last_data == (exp_data & 16'hFFFF), "R4 pixel order", last_data, exp_data & 16'hFFFF);
        exp_data++;
        writes++;
        in_pix = 0; seen_wr = 0; pre_c = 0; act_c = 0; post_c = 0;
      end
    end
  end

  task automatic set_cfg(input logic [15:0] v);
    cfg_timing = {12'b0, v, 3'b0, 1'b1};
    exp_pre  = int'(v[15:12]) + int'(v[11:8]);
    exp_act  = (v[7:4] == 0) ? 1 : int'(v[7:4]);
    exp_post = int'(v[3:0]);
  endtask

  task automatic write_trig(input logic [31:0] v);
    @(negedge clk); trig_we = 1'b1; trig_wdata = v;
    @(negedge clk); trig_we = 1'b0; trig_wdata = '0;
  endtask

  task automatic te_pulse();
    @(negedge clk); te_in = 1'b1;
    repeat (3) @(negedge clk);
    te_in = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, req, busy, 0);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stimulus vectors: {css, wrs, act, hold} nibbles
  localparam logic [15:0] VEC [6] = '{16'h0010, 16'h0000, 16'h1234, 16'hF0F1, 16'h0503, 16'h2101};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_cycles(3);
    @(negedge clk);
    chk(lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1, "R9 reset bus idle", {lcd_cs_n, lcd_wr_n}, 3);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    rst_n = 1'b1;
    idle_cycles(2);

    // vector walk: software-triggered frames
    for (int i = 0; i < 6; i++) begin
      set_cfg(VEC[i]);
      writes = 0;
      write_trig(32'h0000_0003);
      chk(busy == 1'b1, "R5 R9 sw trigger starts", busy, 1);
      wait_idle("R9 frame ends");
      chk(irq == 1'b1, "R10 irq after frame", irq, 1);
      idle_cycles(1);
      chk(writes == NPIX, "R4 pixels per frame", writes, NPIX);
      idle_cycles(4);
      chk(irq == 1'b1, "R10 irq sticky", irq, 1);
      clear_irq();
    end

    // trigger word without both bits does nothing
    set_cfg(16'h0010);
    writes = 0;
    write_trig(32'h0000_0002);
    idle_cycles(4);
    chk(busy == 1'b0 && writes == 0, "R5 command without mode", busy, 0);
    write_trig(32'h0000_0001);
    idle_cycles(4);
    chk(busy == 1'b0 && writes == 0, "R5 mode without command", busy, 0);

    // requests during a frame are dropped
    set_cfg(16'h3432);
    writes = 0;
    write_trig(32'h0000_0003);
    idle_cycles(20);
    write_trig(32'h0000_0003);
    write_trig(32'h8000_0008);
    te_pulse();
    wait_idle("R7 frame ends");
    idle_cycles(30);
    chk(busy == 1'b0, "R7 no queued frame", busy, 0);
    chk(writes == NPIX, "R7 single frame", writes, NPIX);
    clear_irq();
    write_trig(32'h0);

    // timing captured at start
    set_cfg(16'h1212);
    writes = 0;
    write_trig(32'h0000_0003);
    idle_cycles(5);
    cfg_timing = {12'b0, 16'h5555, 4'b0001};
    wait_idle("R11 frame ends");
    idle_cycles(1);
    chk(writes == NPIX, "R11 frame completes", writes, NPIX);
    clear_irq();

    // interface disabled
    set_cfg(16'h0010);
    cfg_timing[0] = 1'b0;
    writes = 0;
    write_trig(32'h0000_0003);
    idle_cycles(5);
    chk(busy == 1'b0 && writes == 0, "R8 sw discarded", busy, 0);
    write_trig(32'h8000_0008);
    te_pulse();
    idle_cycles(6);
    chk(busy == 1'b0 && writes == 0, "R8 te discarded", busy, 0);
    cfg_timing[0] = 1'b1;

    // one-shot tearing trigger
    write_trig(32'h0000_0008);
    writes = 0;
    te_pulse();
    idle_cycles(2);
    chk(busy == 1'b1, "R6 first te starts", busy, 1);
    wait_idle("R6 frame ends");
    clear_irq();
    te_pulse();
    idle_cycles(6);
    chk(busy == 1'b0, "R6 one-shot spent", busy, 0);
    write_trig(32'h0000_0008);
    te_pulse();
    idle_cycles(2);
    chk(busy == 1'b1, "R6 rearmed", busy, 1);
    wait_idle("R6 frame ends");
    clear_irq();

    // every tearing pulse
    write_trig(32'h8000_0008);
    for (int k = 0; k < 2; k++) begin
      te_pulse();
      idle_cycles(2);
      chk(busy == 1'b1, "R6 per-pulse start", busy, 1);
      wait_idle("R6 frame ends");
      clear_irq();
    end

    // masked tearing
    write_trig(32'h8000_0018);
    writes = 0;
    te_pulse();
    idle_cycles(6);
    chk(busy == 1'b0 && writes == 0, "R6 masked", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule